// File: doc/BRIEF.md
# Preloaded Serial Transmit Shift Register

This block is the transmit data path of a serial radio link. Two chained byte stages form one shift path, and the top bit of the upper stage drives the outgoing line. While the transmitter enable is high, each bit-clock pulse moves the path left by one bit, so bytes leave MSB first. A host hands over the next byte through a single-cycle byte-write strobe. After every eight bits the block raises a ready flag and a one-cycle interrupt, which tell the host there is room for another byte.

At reset both stages hold the alternating pattern 0xAA, so turning the transmitter on with nothing written sends a preamble at once. The path is circular: bits leaving the top re-enter at the bottom. With no new write the current contents repeat. Dropping the enable flushes everything still queued. The preamble is not restored afterwards.

Top module: `tx_preload_shifter`

## Requirements
- R1: After reset, both byte stages hold 0xAA, `tx_bit` is 1, and `ready` and `irq` are 0.
- R2: Enabling the transmitter with no byte written sends the alternating preamble 1,0,1,0,... from the first bit pulse on, with no start delay.
- R3: While enabled, each `bit_tick` pulse advances the line by one bit, MSB first, in the cycle after the pulse. With no pulse, `tx_bit` holds.
- R4: After every eighth shifted bit since enable, `irq` is high for exactly one cycle and `ready` becomes 1 in that same cycle.
- R5: A `wr_strobe` clears `ready` in the next cycle. A byte written while `ready` is 1, before the next bit pulse, is sent MSB first right after the byte now in the upper stage.
- R6: When no byte is written at a boundary, the path keeps rotating: the two bytes it holds go out again in turn.
- R7: A falling edge of `tx_en` discards all queued bits. `tx_bit` reads 0 in the next cycle, and a later enable with no write sends 0x00 bytes, not 0xAA.
- R8: A falling edge of `tx_en` clears `ready` and restarts the bit count, so the first `irq` after re-enable comes on the eighth bit pulse.
- R9: A byte written while disabled goes to the lower stage. After re-enable, eight zero bits go out, then that byte.
- R10: While `tx_en` is low, `bit_tick` pulses shift nothing and raise no `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| wr_strobe | input | 1 | Byte-write strobe from the host |
| wr_byte | input | BYTE_W | Byte to load into the lower stage |
| tx_bit | output | 1 | Serial data out (MSB of the upper stage) |
| ready | output | 1 | Room for the next byte |
| irq | output | 1 | One-cycle pulse at each byte boundary |

## Verification
The bench sweeps all 256 byte values through the handoff at successive boundaries. A design that loaded the wrong stage, or swapped the bit order, would send each byte out of turn or bit-reversed. After the last write it lets the path rotate, which catches a design that shifts in zeros or reloads the preamble instead of recirculating. It drops the enable partway through a byte and then re-enables. A design that kept the queued bits, restored 0xAA or kept the old bit count would send the wrong byte or pulse `irq` early. It also pulses the bit clock while disabled, both from reset and after a disable, which exposes a design that shifts or counts without the enable.

// File: rtl/tx_shift_pkg.sv
package tx_shift_pkg;

  localparam int unsigned MIN_BYTE_W = 2;

  function automatic logic last_slot(input int unsigned cnt, input int unsigned width);
    return cnt == (width - 1);
  endfunction

endpackage

// File: rtl/tx_shift_stage.sv
module tx_shift_stage #(
  parameter int unsigned W        = 8,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter bit          HAS_LOAD = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         shift,
  input  logic         ser_in,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic [W-1:0] data,
  output logic         ser_out
);

  logic [W-1:0] nxt;

  always_comb begin
    nxt = data;
    if (clear)      nxt = '0;
    else if (shift) nxt = {data[W-2:0], ser_in};
    if (HAS_LOAD && load) nxt = load_data;
  end

  always_ff @(posedge clk) begin
    if (rst) data <= RST_VAL;
    else     data <= nxt;
  end

  assign ser_out = data[W-1];

  p_clear_empties_r7: assert property (@(posedge clk) disable iff (rst)
    (clear && !(HAS_LOAD && load)) |=> (data == '0));

  p_serial_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (shift && !clear && !(HAS_LOAD && load)) |=> (data[0] == $past(ser_in)));

endmodule

// File: rtl/tx_bit_counter.sv
module tx_bit_counter
  import tx_shift_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic shift,
  output logic boundary
);

  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last  = last_slot(int'(cnt), W);
  assign boundary = shift && at_last;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (clear)      cnt <= '0;
    else if (boundary)   cnt <= '0;
    else if (shift)      cnt <= cnt + 1'b1;
  end

  p_count_moves_r8: assert property (@(posedge clk) disable iff (rst)
    (shift && !clear) |=> (cnt != $past(cnt)));

endmodule

// File: rtl/tx_ready_ctrl.sv
module tx_ready_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic boundary,
  input  logic wr,
  output logic ready,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= boundary && !clear;
      if (clear || wr)   ready <= 1'b0;
      else if (boundary) ready <= 1'b1;
    end
  end

  p_wr_clears_ready_r5: assert property (@(posedge clk) disable iff (rst)
    wr |=> !ready);

  p_irq_single_r4: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

endmodule

// File: rtl/tx_preload_shifter.sv
module tx_preload_shifter
  import tx_shift_pkg::*;
#(
  parameter int unsigned     BYTE_W      = 8,
  parameter int unsigned     NUM_STAGES  = 2,
  parameter logic [BYTE_W-1:0] PRELOAD   = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              bit_tick,
  input  logic              wr_strobe,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              tx_bit,
  output logic              ready,
  output logic              irq
);

  localparam int unsigned TOP = NUM_STAGES - 1;

  logic en_q;
  logic dis_edge;
  logic do_shift;
  logic boundary;
  logic [NUM_STAGES-1:0] ser;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= tx_en;
  end

  assign dis_edge = en_q && !tx_en;
  assign do_shift = tx_en && bit_tick;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    logic [BYTE_W-1:0] st_data;
    if (i == 0) begin : g_low
      tx_shift_stage #(.W(BYTE_W), .RST_VAL(PRELOAD), .HAS_LOAD(1'b1)) u_stage (
        .clk(clk), .rst(rst), .clear(dis_edge), .shift(do_shift),
        .ser_in(ser[TOP]), .load(wr_strobe), .load_data(wr_byte),
        .data(st_data), .ser_out(ser[i]));
    end else begin : g_up
      tx_shift_stage #(.W(BYTE_W), .RST_VAL(PRELOAD), .HAS_LOAD(1'b0)) u_stage (
        .clk(clk), .rst(rst), .clear(dis_edge), .shift(do_shift),
        .ser_in(ser[i-1]), .load(1'b0), .load_data('0),
        .data(st_data), .ser_out(ser[i]));
    end
  end

  tx_bit_counter #(.W(BYTE_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(dis_edge), .shift(do_shift), .boundary(boundary));

  tx_ready_ctrl u_rdy (
    .clk(clk), .rst(rst), .clear(dis_edge), .boundary(boundary), .wr(wr_strobe),
    .ready(ready), .irq(irq));

  assign tx_bit = ser[TOP];

  initial begin
    p_cfg_r1: assert (BYTE_W >= MIN_BYTE_W && NUM_STAGES >= 2);
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!do_shift && !dis_edge) |=> $stable(tx_bit));

  p_disable_flush_r7: assert property (@(posedge clk) disable iff (rst)
    dis_edge |=> (!tx_bit && !ready && !irq));

  p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(tx_en));

endmodule

// File: tb/test_tx_preload_shifter.sv
module test_tx_preload_shifter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic       bit_tick = 1'b0;
  logic       wr_strobe = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       tx_bit, ready, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tx_preload_shifter i_tx_preload_shifter (
    .clk(clk), .rst(rst), .tx_en(tx_en), .bit_tick(bit_tick),
    .wr_strobe(wr_strobe), .wr_byte(wr_byte),
    .tx_bit(tx_bit), .ready(ready), .irq(irq));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] exp, input int n, input string tag);
    for (int j = 0; j < n; j++) begin
      int k = 7 - j;
      check(tx_bit, exp[k], tag);
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
      check(irq, (k == 0), "R4 irq at boundary");
      if (k == 0) check(ready, 1, "R4 ready at boundary");
      for (int g = 0; g < (j % 3); g++) begin
        logic hold;
        hold = tx_bit;
        @(negedge clk);
        check(irq, 0, "R4 single irq pulse");
        if (k != 0) check(tx_bit, hold, "R3 hold without tick");
      end
    end
  endtask

  task automatic write_byte(input logic [7:0] v);
    @(negedge clk) begin wr_strobe = 1'b1; wr_byte = v; end
    @(negedge clk) wr_strobe = 1'b0;
    check(ready, 0, "R5 write clears ready");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tx_bit, 1, "R1 tx_bit");
    check(ready, 0, "R1 ready");
    check(irq, 0, "R1 irq");

    for (int t = 0; t < 5; t++) begin
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
      check(tx_bit, 1, "R10 no shift while off");
      check(irq, 0, "R10 no irq while off");
    end

    @(negedge clk) tx_en = 1'b1;
    send_bits(8'hAA, 8, "R2 preamble first byte");
    send_bits(8'hAA, 8, "R2 preamble second byte");

    begin
      logic [7:0] prev;
      prev = 8'hAA;
      for (int v = 0; v < 256; v++) begin
        write_byte(v[7:0]);
        send_bits(prev, 8, "R5 handoff sweep");
        prev = v[7:0];
      end
    end
    send_bits(8'hFF, 8, "R6 rotate last");
    send_bits(8'hFE, 8, "R6 rotate repeat");
    send_bits(8'hFF, 8, "R6 rotate again");

    send_bits(8'hFE, 3, "R7 partial byte");
    @(negedge clk) tx_en = 1'b0;
    @(negedge clk);
    check(tx_bit, 0, "R7 flushed line");
    check(ready, 0, "R8 ready cleared");
    for (int t = 0; t < 3; t++) begin
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
      check(tx_bit, 0, "R10 idle after disable");
      check(irq, 0, "R10 no irq after disable");
    end
    @(negedge clk) tx_en = 1'b1;
    send_bits(8'h00, 8, "R8 count restarts");
    send_bits(8'h00, 8, "R7 preload not restored");

    @(negedge clk) tx_en = 1'b0;
    @(negedge clk);
    write_byte(8'hC3);
    @(negedge clk) tx_en = 1'b1;
    send_bits(8'h00, 8, "R9 zeros before byte");
    send_bits(8'hC3, 8, "R9 byte written while off");
    send_bits(8'h00, 8, "R6 rotate after R9");
    send_bits(8'hC3, 8, "R6 rotate after R9 again");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule